// File: doc/BRIEF.md
# Rotating Register Window Controller

This block lets a processor core see a fixed set of sixteen logical registers through a window that slides over a larger physical register file. The physical file holds NAREG words, grouped into panes of four. A pane-granular base pointer sets where logical register 0 lands. A bitmap with one bit per pane marks the panes where a call frame begins.

The core issues one operation at a time: frame allocation on subroutine entry, frame release on return, a free rotation by a signed pane count, a jump of the base back to a saved value, a check that space is free ahead of the current frame, and a check before the stack pointer is moved. The block does the window arithmetic. It writes the callee stack pointer on entry and produces the return target. It reports overflow, underflow, illegal-operation and stack-move exceptions, together with the saved base and PC that a spill or fill handler needs. The core's status register stays outside the block: the overflow-enable, exception-mode, call-increment and saved-base fields come in as inputs, and the block reports the new saved base with each exception.

Top module: `winRegCtl`

## Requirements
- R1: After reset the base pointer is 0, the start bitmap holds only the bit for pane 0, and opDone, excValid and retValid are low.
- R2: Logical register r (0..15) maps to physical index (base*4 + r) mod NAREG. rdPhys shows that index and rdData shows the word stored there. A write through wrEn stores wrData at the mapped index of wrLogical.
- R3: An operation requested with opValid is carried out at that clock edge. opDone is high for exactly the next cycle, and the read port uses the new mapping from that cycle. Exception and return outputs are valid only while opDone is high. With no request, the base and bitmap hold. Op codes are: 0 entry, 1 return, 2 rotate, 3 restore, 4 check, 5 stack-move. Codes 6 and 7 complete with no effect.
- R4: Entry and return are legal only when psWoe is 1 and psExcm is 0. Otherwise they raise the illegal exception and change no state. Under the same condition a check does nothing.
- R5: Entry with opStack above 3 is illegal. Otherwise it writes (logical opStack) minus opImm*8 into logical register psCallInc*4 + opStack of the pre-rotation window. It then adds psCallInc to the base modulo NAREG/4 and sets the start bit of the new base.
- R6: A check with w = opCount (only distances 1..3 are scanned) finds the smallest n in 1..w whose pane at base+n has its start bit set. If none is found, nothing happens. Otherwise the base advances by n, an exception is raised with excOwb = the old base and excPc = pcIn. The exception codes are: 0 overflow-4, 1 overflow-8, 2 overflow-12, 3 underflow-4, 4 underflow-8, 5 underflow-12, 6 illegal, 7 stack-move.
- R7: For a check that finds n, with m = base+n, the kind is overflow-4 if pane m+1 is marked, else overflow-8 if pane m+2 is marked, else overflow-12.
- R8: Return takes n from bits 31:30 of logical register 0. It takes m as the first of distances 1, 2, 3 below the base whose pane is marked, or 0 if none is marked. It is illegal when n is 0, or when m is nonzero and differs from n.
- R9: A legal return raises retValid with retPc = pcIn[31:30] concatenated with bits 29:0 of logical register 0.
- R10: A legal return moves the base back by n. If the new base's pane is marked, the old base's start bit is cleared. Otherwise an underflow of size 4, 8 or 12 (for n = 1, 2, 3) is raised, with excOwb = the old base and the bitmap unchanged.
- R11: Rotate adds the signed 4-bit opCount to the base, modulo NAREG/4.
- R12: Restore loads the base from psOwb and leaves the bitmap unchanged.
- R13: Stack-move raises exception 7 when none of the panes at base-1, base-2 and base-3 is marked, and changes no state in any case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation request, one cycle |
| opCode | input | 3 | Operation code |
| opStack | input | 4 | Stack register operand of entry |
| opImm | input | IMM_W | Frame size in 8-byte units for entry |
| opCount | input | 4 | Signed rotate amount, or panes to check |
| pcIn | input | DW | PC of the operation |
| psWoe | input | 1 | Window overflow enable |
| psExcm | input | 1 | Exception mode |
| psCallInc | input | 2 | Call increment in panes |
| psOwb | input | PB | Saved base for restore |
| wrEn | input | 1 | Register write enable |
| wrLogical | input | 4 | Logical register to write |
| wrData | input | DW | Write data |
| rdLogical | input | 4 | Logical register to read |
| rdData | output | DW | Read data |
| rdPhys | output | IW | Physical index of rdLogical |
| windowBase | output | PB | Current base pointer |
| windowStart | output | NAREG/4 | Start bitmap |
| opDone | output | 1 | Operation completed |
| excValid | output | 1 | Exception raised |
| excKind | output | 3 | Exception code |
| excOwb | output | PB | Base to save in the status register |
| excPc | output | DW | PC to record |
| retValid | output | 1 | Legal return completed |
| retPc | output | DW | Return target |

## Verification
A wrong base pointer shows on rdPhys and rdData for every logical register in the cycle after the operation that corrupted it, so a full read-back sweep follows every operation. A wrong start bit can stay hidden until a later check, return or stack-move scans that pane. For that reason a long mixed sequence of operations runs against an arithmetic model on a four-pane file, where every scan distance wraps and every bitmap pattern can be reached. Exception kind, saved base, PC and return target are compared in the single cycle where opDone is high.

// File: rtl/winPkg.sv
package winPkg;

  typedef enum logic [2:0] {
    OP_ENTRY   = 3'd0,
    OP_RETURN  = 3'd1,
    OP_ROTATE  = 3'd2,
    OP_RESTORE = 3'd3,
    OP_CHECK   = 3'd4,
    OP_SPMOVE  = 3'd5
  } winOp_e;

  typedef enum logic [2:0] {
    EXC_OVF4    = 3'd0,
    EXC_OVF8    = 3'd1,
    EXC_OVF12   = 3'd2,
    EXC_UNF4    = 3'd3,
    EXC_UNF8    = 3'd4,
    EXC_UNF12   = 3'd5,
    EXC_ILLEGAL = 3'd6,
    EXC_ALLOCA  = 3'd7
  } winExc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rotate;    // base <= base + delta
    logic loadAbs;   // base <= absBase
    logic setStart;  // mark pane of new base
    logic clrStart;  // unmark pane of old base
    logic regWrite;  // write register through old mapping
  } winStrobe_t;

endpackage

// File: rtl/winDatapath.sv
module winDatapath
  import winPkg::*;
#(
  parameter int NAREG = 16,
  parameter int DW    = 32,
  localparam int PANES = NAREG / 4,
  localparam int PB    = $clog2(PANES),
  localparam int IW    = $clog2(NAREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  winStrobe_t      strobe,
  input  logic [PB-1:0]   delta,
  input  logic [PB-1:0]   absBase,
  input  logic [3:0]      opLogical,
  input  logic [DW-1:0]   opData,
  input  logic            extWe,
  input  logic [3:0]      extLogical,
  input  logic [DW-1:0]   extData,
  input  logic [3:0]      rdLogical,
  input  logic [3:0]      auxLogical,
  output logic [DW-1:0]   rdData,
  output logic [IW-1:0]   rdPhys,
  output logic [DW-1:0]   auxData,
  output logic [PB-1:0]   base,
  output logic [PANES-1:0] start
);

  logic [DW-1:0]    regs [NAREG];
  logic [PB-1:0]    baseNext;
  logic [PANES-1:0] startNext;
  logic [IW-1:0]    auxPhys;
  logic [IW-1:0]    wrPhys;
  logic             wrAny;
  logic [DW-1:0]    wrVal;

  function automatic logic [IW-1:0] physOf(input logic [PB-1:0] b, input logic [3:0] lr);
    return IW'({b, 2'b00}) + IW'(lr);
  endfunction

  assign rdPhys  = physOf(base, rdLogical);
  assign auxPhys = physOf(base, auxLogical);
  assign rdData  = regs[rdPhys];
  assign auxData = regs[auxPhys];

  always_comb begin
    baseNext = base;
    if (strobe.rotate)       baseNext = base + delta;
    else if (strobe.loadAbs) baseNext = absBase;
    startNext = start;
    if (strobe.clrStart) startNext[base] = 1'b0;
    if (strobe.setStart) startNext[baseNext] = 1'b1;
  end

  // operation write wins over the external port
  always_comb begin
    if (strobe.regWrite) begin
      wrAny  = 1'b1;
      wrPhys = physOf(base, opLogical);
      wrVal  = opData;
    end else begin
      wrAny  = extWe;
      wrPhys = physOf(base, extLogical);
      wrVal  = extData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base  <= '0;
      start <= PANES'(1);
    end else begin
      base  <= baseNext;
      start <= startNext;
    end
  end

  always_ff @(posedge clk) begin
    if (wrAny) regs[wrPhys] <= wrVal;
  end

endmodule

// File: rtl/winControl.sv
module winControl
  import winPkg::*;
#(
  parameter int NAREG = 16,
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  localparam int PANES = NAREG / 4,
  localparam int PB    = $clog2(PANES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic [3:0]       opStack,
  input  logic [IMM_W-1:0] opImm,
  input  logic [3:0]       opCount,
  input  logic [DW-1:0]    pcIn,
  input  logic             psWoe,
  input  logic             psExcm,
  input  logic [1:0]       psCallInc,
  input  logic [PB-1:0]    psOwb,
  input  logic [PB-1:0]    base,
  input  logic [PANES-1:0] start,
  input  logic [DW-1:0]    auxData,
  output logic [3:0]       auxLogical,
  output winStrobe_t       strobe,
  output logic [PB-1:0]    delta,
  output logic [PB-1:0]    absBase,
  output logic [3:0]       opLogical,
  output logic [DW-1:0]    opData,
  output logic             opDone,
  output logic             excValid,
  output logic [2:0]       excKind,
  output logic [PB-1:0]    excOwb,
  output logic [DW-1:0]    excPc,
  output logic             retValid,
  output logic [DW-1:0]    retPc
);

  winOp_e        op;
  winExc_e       kind;
  logic          active;
  logic          excFire;
  logic          retFire;
  logic [DW-1:0] retTarget;
  logic [1:0]    scanAhead;
  logic [1:0]    scanBehind;
  logic [1:0]    retN;
  logic [PB-1:0] landing;

  function automatic logic markedAt(input logic [PANES-1:0] bm, input logic [PB-1:0] idx);
    return bm[idx];
  endfunction

  assign op         = winOp_e'(opCode);
  assign active     = psWoe && !psExcm;
  assign auxLogical = (op == OP_RETURN) ? 4'd0 : opStack;
  assign retN       = auxData[DW-1:DW-2];
  assign retTarget  = {pcIn[DW-1:DW-2], auxData[DW-3:0]};

  // nearest marked pane ahead of the base, limited to w = opCount
  always_comb begin
    scanAhead = 2'd0;
    for (int d = 3; d >= 1; d--) begin
      if (d <= int'(opCount) && markedAt(start, base + PB'(d))) scanAhead = 2'(d);
    end
  end

  // nearest marked pane behind the base
  always_comb begin
    scanBehind = 2'd0;
    for (int d = 3; d >= 1; d--) begin
      if (markedAt(start, base - PB'(d))) scanBehind = 2'(d);
    end
  end

  assign landing = base + PB'(scanAhead);

  always_comb begin
    strobe    = '0;
    delta     = '0;
    absBase   = '0;
    opLogical = '0;
    opData    = '0;
    excFire   = 1'b0;
    kind      = EXC_ILLEGAL;
    retFire   = 1'b0;
    if (opValid) begin
      unique case (opCode)
        3'd0: begin
          if (opStack > 4'd3 || !active) begin
            excFire = 1'b1;
          end else begin
            strobe.regWrite = 1'b1;
            opLogical       = {psCallInc, opStack[1:0]};
            opData          = auxData - (DW'(opImm) << 3);
            strobe.rotate   = 1'b1;
            delta           = PB'(psCallInc);
            strobe.setStart = 1'b1;
          end
        end
        3'd1: begin
          if (!active || retN == 2'd0 || (scanBehind != 2'd0 && scanBehind != retN)) begin
            excFire = 1'b1;
          end else begin
            retFire       = 1'b1;
            strobe.rotate = 1'b1;
            delta         = PB'(0) - PB'(retN);
            if (markedAt(start, base - PB'(retN))) begin
              strobe.clrStart = 1'b1;
            end else begin
              excFire = 1'b1;
              kind    = (retN == 2'd1) ? EXC_UNF4 : (retN == 2'd2) ? EXC_UNF8 : EXC_UNF12;
            end
          end
        end
        3'd2: begin
          strobe.rotate = 1'b1;
          delta         = PB'($signed(opCount));
        end
        3'd3: begin
          strobe.loadAbs = 1'b1;
          absBase        = psOwb;
        end
        3'd4: begin
          if (active && scanAhead != 2'd0) begin
            strobe.rotate = 1'b1;
            delta         = PB'(scanAhead);
            excFire       = 1'b1;
            if (markedAt(start, landing + PB'(1)))      kind = EXC_OVF4;
            else if (markedAt(start, landing + PB'(2))) kind = EXC_OVF8;
            else                                        kind = EXC_OVF12;
          end
        end
        3'd5: begin
          if (scanBehind == 2'd0) begin
            excFire = 1'b1;
            kind    = EXC_ALLOCA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opDone   <= 1'b0;
      excValid <= 1'b0;
      excKind  <= '0;
      excOwb   <= '0;
      excPc    <= '0;
      retValid <= 1'b0;
      retPc    <= '0;
    end else begin
      opDone   <= opValid;
      excValid <= excFire;
      excKind  <= excFire ? 3'(kind) : 3'd0;
      excOwb   <= excFire ? base : '0;
      excPc    <= excFire ? pcIn : '0;
      retValid <= retFire;
      retPc    <= retFire ? retTarget : '0;
    end
  end

endmodule

// File: rtl/winRegCtl.sv
module winRegCtl
  import winPkg::*;
#(
  parameter int NAREG = 16,
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  localparam int PANES = NAREG / 4,
  localparam int PB    = $clog2(PANES),
  localparam int IW    = $clog2(NAREG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic [3:0]       opStack,
  input  logic [IMM_W-1:0] opImm,
  input  logic [3:0]       opCount,
  input  logic [DW-1:0]    pcIn,
  input  logic             psWoe,
  input  logic             psExcm,
  input  logic [1:0]       psCallInc,
  input  logic [PB-1:0]    psOwb,
  input  logic             wrEn,
  input  logic [3:0]       wrLogical,
  input  logic [DW-1:0]    wrData,
  input  logic [3:0]       rdLogical,
  output logic [DW-1:0]    rdData,
  output logic [IW-1:0]    rdPhys,
  output logic [PB-1:0]    windowBase,
  output logic [PANES-1:0] windowStart,
  output logic             opDone,
  output logic             excValid,
  output logic [2:0]       excKind,
  output logic [PB-1:0]    excOwb,
  output logic [DW-1:0]    excPc,
  output logic             retValid,
  output logic [DW-1:0]    retPc
);

  winStrobe_t    strobe;
  logic [PB-1:0] delta;
  logic [PB-1:0] absBase;
  logic [3:0]    opLogical;
  logic [DW-1:0] opData;
  logic [3:0]    auxLogical;
  logic [DW-1:0] auxData;

  winControl #(.NAREG(NAREG), .DW(DW), .IMM_W(IMM_W)) uCtl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opStack(opStack),
    .opImm(opImm), .opCount(opCount), .pcIn(pcIn), .psWoe(psWoe), .psExcm(psExcm),
    .psCallInc(psCallInc), .psOwb(psOwb), .base(windowBase), .start(windowStart),
    .auxData(auxData), .auxLogical(auxLogical), .strobe(strobe), .delta(delta),
    .absBase(absBase), .opLogical(opLogical), .opData(opData), .opDone(opDone),
    .excValid(excValid), .excKind(excKind), .excOwb(excOwb), .excPc(excPc),
    .retValid(retValid), .retPc(retPc)
  );

  winDatapath #(.NAREG(NAREG), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .delta(delta), .absBase(absBase),
    .opLogical(opLogical), .opData(opData), .extWe(wrEn), .extLogical(wrLogical),
    .extData(wrData), .rdLogical(rdLogical), .auxLogical(auxLogical), .rdData(rdData),
    .rdPhys(rdPhys), .auxData(auxData), .base(windowBase), .start(windowStart)
  );

endmodule

// File: rtl/winRegCtlChk.sv
module winRegCtlChk #(
  parameter int NAREG = 16,
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  localparam int PANES = NAREG / 4,
  localparam int PB    = $clog2(PANES),
  localparam int IW    = $clog2(NAREG)
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [2:0]       opCode,
  input logic [3:0]       opStack,
  input logic [IMM_W-1:0] opImm,
  input logic [3:0]       opCount,
  input logic [DW-1:0]    pcIn,
  input logic             psWoe,
  input logic             psExcm,
  input logic [1:0]       psCallInc,
  input logic [PB-1:0]    psOwb,
  input logic             wrEn,
  input logic [3:0]       wrLogical,
  input logic [DW-1:0]    wrData,
  input logic [3:0]       rdLogical,
  input logic [DW-1:0]    rdData,
  input logic [IW-1:0]    rdPhys,
  input logic [PB-1:0]    windowBase,
  input logic [PANES-1:0] windowStart,
  input logic             opDone,
  input logic             excValid,
  input logic [2:0]       excKind,
  input logic [PB-1:0]    excOwb,
  input logic [DW-1:0]    excPc,
  input logic             retValid,
  input logic [DW-1:0]    retPc
);

  AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> opDone); // R3
  AST_EXC_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (excValid || retValid) |-> opDone); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(windowBase) && $stable(windowStart))); // R3
  AST_GATED_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (psExcm || !psWoe) && (opCode == 3'd0 || opCode == 3'd1))
      |=> (excValid && excKind == 3'd6)); // R4
  AST_CHECK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (psExcm || !psWoe) && opCode == 3'd4)
      |=> (!excValid && $stable(windowBase))); // R4
  AST_ENTRY_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd0) |=> (excValid || windowStart[windowBase])); // R5
  AST_RETURN_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd1) |=> (!retValid || excValid || windowStart[windowBase])); // R10
  AST_RESTORE_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd3) |=> (windowBase == $past(psOwb))); // R12
  AST_SPMOVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd5) |=> ($stable(windowBase) && $stable(windowStart))); // R13

endmodule

bind winRegCtl winRegCtlChk #(.NAREG(NAREG), .DW(DW), .IMM_W(IMM_W)) uChk (.*);

// File: tb/tb_winRegCtl.sv
`timescale 1ns/1ps
module tb_winRegCtl;

  localparam int NAREG = 16;
  localparam int P     = NAREG / 4;
  localparam int PB    = $clog2(P);
  localparam int IW    = $clog2(NAREG);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [2:0] opCode = '0;
  logic [3:0] opStack = '0;
  logic [11:0] opImm = '0;
  logic [3:0] opCount = '0;
  logic [31:0] pcIn = '0;
  logic psWoe = 1'b1, psExcm = 1'b0;
  logic [1:0] psCallInc = '0;
  logic [PB-1:0] psOwb = '0;
  logic wrEn = 1'b0;
  logic [3:0] wrLogical = '0;
  logic [31:0] wrData = '0;
  logic [3:0] rdLogical = '0;
  logic [31:0] rdData;
  logic [IW-1:0] rdPhys;
  logic [PB-1:0] windowBase;
  logic [P-1:0] windowStart;
  logic opDone, excValid, retValid;
  logic [2:0] excKind;
  logic [PB-1:0] excOwb;
  logic [31:0] excPc, retPc;

  winRegCtl dut (.*);

  always #2.5 clk = ~clk;

  int nRun = 0, nFail = 0;
  int mBase;
  logic [P-1:0] mWs;
  logic [31:0] mRegs [NAREG];

  task automatic chk(string req, string what, longint act, longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pm(int v); return ((v % P) + P) % P; endfunction
  function automatic int ph(int r); return (mBase * 4 + r) % NAREG; endfunction

  task automatic sweep(string req);
    int bad = 0;
    for (int r = 0; r < 16; r++) begin
      rdLogical = 4'(r);
      #0.1;
      if (rdPhys != IW'(ph(r)) || rdData != mRegs[ph(r)]) bad++;
    end
    chk(req, "read-back mismatches", bad, 0);
  endtask

  task automatic wr(int l, logic [31:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrLogical = 4'(l); wrData = v;
    @(posedge clk);
    mRegs[ph(l)] = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doOp(int code, int s, int imm, int cnt, logic [31:0] pc,
                      bit woe, bit excm, int ci, int owb);
    bit eExc = 0, eRet = 0;
    int eKind = 0, eOwb = 0;
    logic [31:0] eRetPc = 0;
    bit act = woe && !excm;
    string req;
    int n, m;
    logic [31:0] r0;
    @(negedge clk);
    opValid = 1; opCode = 3'(code); opStack = 4'(s); opImm = 12'(imm);
    opCount = 4'(cnt); pcIn = pc; psWoe = woe; psExcm = excm;
    psCallInc = 2'(ci); psOwb = PB'(owb);
    case (code)
      0: begin
        req = "R5";
        if (s > 3 || !act) begin eExc = 1; eKind = 6; if (!act) req = "R4"; end
        else begin
          mRegs[ph(ci * 4 + s)] = mRegs[ph(s)] - 32'(imm * 8);
          mBase = pm(mBase + ci);
          mWs[mBase] = 1'b1;
        end
      end
      1: begin
        req = "R10";
        r0 = mRegs[ph(0)];
        n = int'(r0[31:30]);
        m = mWs[pm(mBase - 1)] ? 1 : mWs[pm(mBase - 2)] ? 2 : mWs[pm(mBase - 3)] ? 3 : 0;
        if (!act || n == 0 || (m != 0 && m != n)) begin
          eExc = 1; eKind = 6; req = act ? "R8" : "R4";
        end else begin
          eRet = 1; eRetPc = {pc[31:30], r0[29:0]};
          if (mWs[pm(mBase - n)]) mWs[mBase] = 1'b0;
          else begin eExc = 1; eKind = 2 + n; eOwb = mBase; end
          mBase = pm(mBase - n);
        end
      end
      2: begin req = "R11"; mBase = pm(mBase + ((cnt >= 8) ? cnt - 16 : cnt)); end
      3: begin req = "R12"; mBase = owb; end
      4: begin
        req = "R6";
        n = 0;
        if (act) for (int d = 3; d >= 1; d--) if (d <= cnt && mWs[pm(mBase + d)]) n = d;
        if (n != 0) begin
          req = "R7";
          m = pm(mBase + n);
          eExc = 1; eOwb = mBase;
          eKind = mWs[pm(m + 1)] ? 0 : mWs[pm(m + 2)] ? 1 : 2;
          mBase = m;
        end else if (!act) req = "R4";
      end
      5: begin
        req = "R13";
        if (!(mWs[pm(mBase - 1)] || mWs[pm(mBase - 2)] || mWs[pm(mBase - 3)])) begin
          eExc = 1; eKind = 7;
        end
      end
      default: req = "R3";
    endcase
    @(posedge clk);
    @(negedge clk);
    opValid = 0;
    chk("R3", "opDone", opDone, 1);
    chk(req, "excValid", excValid, eExc);
    if (eExc) begin
      chk(req, "excKind", excKind, eKind);
      chk(req, "excPc", excPc, pc);
      if (eKind < 6) chk(req, "excOwb", excOwb, eOwb);
    end
    chk(code == 1 ? "R9" : req, "retValid", retValid, eRet);
    if (eRet) chk("R9", "retPc", retPc, eRetPc);
    chk(req, "windowBase", windowBase, mBase);
    chk(req, "windowStart", windowStart, mWs);
    sweep(req);
  endtask

  initial begin
    #(5.0 * 150000);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    mBase = 0; mWs = 4'b0001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1", "windowBase", windowBase, 0);
    chk("R1", "windowStart", windowStart, 1);
    chk("R1", "opDone", opDone, 0);
    chk("R1", "excValid", excValid, 0);
    chk("R1", "retValid", retValid, 0);
    // R2 fill every physical word through the window
    for (int r = 0; r < 16; r++) wr(r, 32'h1000_0000 + 32'(r * 32'h0101_0101));
    sweep("R2");
    // R11 every signed rotate amount, R3 no-op codes
    for (int c = 0; c < 16; c++) doOp(2, 0, 0, c, 32'h100, 1, 0, 0, 0);
    doOp(6, 0, 0, 0, 32'h104, 1, 0, 0, 0);
    doOp(7, 0, 0, 0, 32'h108, 1, 0, 0, 0);
    doOp(3, 0, 0, 0, 32'h10c, 1, 0, 0, 0);                 // R12 back to 0
    // R4 gating
    doOp(0, 1, 4, 0, 32'h200, 0, 0, 1, 0);
    doOp(1, 0, 0, 0, 32'h204, 1, 1, 0, 0);
    doOp(4, 0, 0, 3, 32'h208, 1, 1, 0, 0);
    // R5 illegal stack operand, R13 no frame behind
    doOp(0, 4, 4, 0, 32'h20c, 1, 0, 1, 0);
    doOp(5, 0, 0, 0, 32'h210, 1, 0, 0, 0);
    // R5 entries: base 0 -> 1 -> 3
    doOp(0, 1, 3, 0, 32'h300, 1, 0, 1, 0);
    doOp(0, 2, 5, 0, 32'h304, 1, 0, 2, 0);
    doOp(5, 0, 0, 0, 32'h308, 1, 0, 0, 0);                 // R13 frame behind
    doOp(2, 0, 0, 13, 32'h30c, 1, 0, 0, 0);                // R11 -3 -> base 0
    doOp(4, 0, 0, 3, 32'h310, 1, 0, 0, 0);                 // R7 overflow-8
    doOp(3, 0, 0, 0, 32'h314, 1, 0, 0, 0);
    doOp(4, 0, 0, 0, 32'h318, 1, 0, 0, 0);                 // R6 w=0 nothing
    // R8/R9/R10 returns
    wr(0, 32'h0000_0040);
    doOp(1, 0, 0, 0, 32'hC000_0400, 1, 0, 0, 0);           // R8 n=0 illegal
    doOp(3, 0, 0, 0, 32'h404, 1, 0, 0, 3);
    wr(0, 32'h8123_4567);
    doOp(1, 0, 0, 0, 32'hC000_0408, 1, 0, 0, 0);           // n=2 from base 3
    wr(0, 32'h4000_0010);
    doOp(1, 0, 0, 0, 32'h4000_040c, 1, 0, 0, 0);           // n=1
    doOp(2, 0, 0, 2, 32'h410, 1, 0, 0, 0);
    wr(0, 32'hC000_0020);
    doOp(1, 0, 0, 0, 32'h414, 1, 0, 0, 0);
    // mixed sequence against the model
    for (int i = 0; i < 600; i++) begin
      int code = int'($urandom % 6);
      if (code == 1 && ($urandom % 2) == 1) wr(0, $urandom);
      if (($urandom % 16) == 0) wr(int'($urandom % 16), $urandom);
      doOp(code, int'($urandom % 5), int'($urandom % 4096), int'($urandom % 16),
           $urandom, ($urandom % 8) != 0, ($urandom % 8) == 0,
           int'($urandom % 4), int'($urandom % P));
    end
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule